// File: doc/BRIEF.md
# Chained Vector Arithmetic Pipeline

This block holds a bank of vector registers and two pipelined integer units, an adder and a multiplier, that walk through the registers one element at a time. An issue port with a valid/ready handshake accepts one vector instruction per cycle. Each instruction names an operation, a destination register, two source registers and a length. A host port writes single elements and reads them back, so that vectors can be loaded before a run and inspected after it.

When an instruction in one unit reads the register that the other unit is still producing, it is chained. It consumes each element in the cycle after that element lands in the register bank, instead of waiting for the whole vector. A multiply followed by a dependent add therefore overlaps almost completely, and in steady state both units retire a result every cycle. Register conflicts that chaining cannot resolve hold the request at the issue port until they clear.

Top module: `vchain_top`

## Requirements
- R1: After reset, `busy` is 0, both `done` bits are 0, and `iss_ready` is 1 when no unit is busy.
- R2: When `iss_op` = 0 (add), destination element i becomes source A element i plus source B element i, modulo 2^64, for every i below `iss_len` (1 to 64). Destination elements at index `iss_len` and above keep their value.
- R3: When `iss_op` = 1 (multiply), destination element i becomes the low 64 bits of A[i]*B[i], for every i below `iss_len`. Destination elements at index `iss_len` and above keep their value.
- R4: The add unit has a latency of 6 and the multiply unit a latency of 7, and each unit starts one element per cycle. For an unobstructed instruction of length N, the unit's `done` bit is high N+latency cycles after the cycle in which the request was presented and accepted.
- R5: An instruction that reads the register being written by the other unit, with a length no greater than the producer's, is accepted at once and is chained. A multiply of length N feeding an add of length N shows `done[0]` N+13 cycles after the multiply is accepted, and the result equals sequential execution.
- R6: If such a dependent instruction is longer than its producer, `iss_ready` stays 0 until the producer has written its last element. Execution is then fully sequential.
- R7: A request whose destination equals a source or the destination of the instruction running in the other unit holds `iss_ready` at 0 until that instruction finishes. The sources that the running instruction reads are not disturbed.
- R8: A request for a unit that is still running its previous instruction holds `iss_ready` at 0.
- R9: `done[0]` (add) and `done[1]` (multiply) are each high for exactly one cycle, in the cycle after the unit's last element is written. In that cycle the unit no longer counts toward `busy`.
- R10: A host write with `hst_we` = 1 stores `hst_wdata` at register `hst_reg`, element `hst_elem`. `hst_rdata` shows the element addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction request present |
| iss_ready | output | 1 | Request can be accepted this cycle |
| iss_op | input | 1 | 0 = add, 1 = multiply |
| iss_dst | input | 3 | Destination register |
| iss_src_a | input | 3 | First source register |
| iss_src_b | input | 3 | Second source register |
| iss_len | input | 7 | Element count, 1 to 64 |
| busy | output | 1 | Some unit is running an instruction |
| done | output | 2 | One-cycle completion pulse per unit (bit 0 add, bit 1 multiply) |
| hst_we | input | 1 | Host element write enable |
| hst_reg | input | 3 | Host register select |
| hst_elem | input | 6 | Host element select |
| hst_wdata | input | 64 | Host write data |
| hst_rdata | output | 64 | Element addressed in the previous cycle |

## Verification
The bench times a chained multiply-add against the N+13 figure. A consumer that waited for the whole producer vector would finish N cycles late. A consumer that read ahead of the producer would pick up stale elements, and the register comparison against the sequential model would expose it. It presents dependents longer than their producer, and destinations that collide with a running instruction's sources or destination. A design that chained blindly would either hang waiting for elements that never come or overwrite operands still being read. Length-1 instructions, and instructions that read and write the same register, check that tail elements survive and that in-place updates are not corrupted. Large operands check that sums and products wrap at 64 bits.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  parameter int REG_N   = 8;
  parameter int ELEM_N  = 64;
  parameter int DW      = 64;
  parameter int ADD_LAT = 6;
  parameter int MUL_LAT = 7;
  parameter int NU      = 2;

  typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} vop_e;
endpackage

// File: rtl/vchain_regbank.sv
module vchain_regbank #(
  parameter int REG_N  = 8,
  parameter int ELEM_N = 64,
  parameter int DW     = 64,
  parameter int RP     = 4,
  parameter int WP     = 2,
  parameter int RW     = 3,
  parameter int EW     = 6
) (
  input  logic          clk,
  input  logic          wr_en   [WP],
  input  logic [RW-1:0] wr_reg  [WP],
  input  logic [EW-1:0] wr_elem [WP],
  input  logic [DW-1:0] wr_data [WP],
  input  logic [RW-1:0] rd_reg  [RP],
  input  logic [EW-1:0] rd_elem [RP],
  output logic [DW-1:0] rd_data [RP],
  input  logic          hst_we,
  input  logic [RW-1:0] hst_reg,
  input  logic [EW-1:0] hst_elem,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata
);
  localparam int DEPTH = REG_N * ELEM_N;

  logic [DW-1:0] mem [DEPTH];

  // unit writes come after the host write, so they win on a clash
  always_ff @(posedge clk) begin
    if (hst_we) mem[{hst_reg, hst_elem}] <= hst_wdata;
    for (int w = 0; w < WP; w++) begin
      if (wr_en[w]) mem[{wr_reg[w], wr_elem[w]}] <= wr_data[w];
    end
    hst_rdata <= mem[{hst_reg, hst_elem}];
  end

  for (genvar p = 0; p < RP; p++) begin : g_rd
    assign rd_data[p] = mem[{rd_reg[p], rd_elem[p]}];
  end
endmodule

// File: rtl/vchain_unit.sv
module vchain_unit #(
  parameter int DW     = 64,
  parameter int RW     = 3,
  parameter int EW     = 6,
  parameter int LW     = 7,
  parameter int LAT    = 6,
  parameter bit IS_MUL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW-1:0] s_dst,
  input  logic [RW-1:0] s_sa,
  input  logic [RW-1:0] s_sb,
  input  logic [LW-1:0] s_len,
  input  logic          s_chain,
  input  logic          other_busy,
  input  logic [LW-1:0] other_wcnt,
  output logic [RW-1:0] rd_reg_a,
  output logic [RW-1:0] rd_reg_b,
  output logic [EW-1:0] rd_elem,
  input  logic [DW-1:0] rd_data_a,
  input  logic [DW-1:0] rd_data_b,
  output logic          wr_en,
  output logic [RW-1:0] wr_reg,
  output logic [EW-1:0] wr_elem,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] cur_dst,
  output logic [RW-1:0] cur_sa,
  output logic [RW-1:0] cur_sb,
  output logic [LW-1:0] cur_len,
  output logic [LW-1:0] wcnt
);
  // LAT-1 pipeline registers; the register-bank write is the last stage
  localparam int NS = LAT - 1;

  logic          busy_q, done_q, chain_q;
  logic [RW-1:0] dst_q, sa_q, sb_q;
  logic [LW-1:0] len_q, rcnt_q, wcnt_q;
  logic          avail, rd_go, last_wr;
  logic [DW-1:0] result;
  logic          pv [NS];
  logic [EW-1:0] pe [NS];
  logic [DW-1:0] pd [NS];

  // a chained read waits until the producer has written that element
  assign avail = !chain_q || !other_busy || (other_wcnt > rcnt_q);
  assign rd_go = busy_q && (rcnt_q < len_q) && avail;

  if (IS_MUL) begin : g_mul
    assign result = rd_data_a * rd_data_b;
  end else begin : g_add
    assign result = rd_data_a + rd_data_b;
  end

  assign last_wr = wr_en && (wcnt_q == len_q - LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      chain_q <= 1'b0;
      dst_q   <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      len_q   <= '0;
      rcnt_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        dst_q   <= s_dst;
        sa_q    <= s_sa;
        sb_q    <= s_sb;
        len_q   <= s_len;
        rcnt_q  <= '0;
        wcnt_q  <= '0;
        chain_q <= s_chain;
      end else begin
        if (rd_go) rcnt_q <= rcnt_q + LW'(1);
        if (chain_q && !other_busy) chain_q <= 1'b0;
        if (wr_en) begin
          wcnt_q <= wcnt_q + LW'(1);
          if (last_wr) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NS; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= rd_go;
      for (int k = 1; k < NS; k++) pv[k] <= pv[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pe[0] <= rcnt_q[EW-1:0];
    pd[0] <= result;
    for (int k = 1; k < NS; k++) begin
      pe[k] <= pe[k-1];
      pd[k] <= pd[k-1];
    end
  end

  assign wr_en    = pv[NS-1];
  assign wr_elem  = pe[NS-1];
  assign wr_data  = pd[NS-1];
  assign wr_reg   = dst_q;
  assign rd_reg_a = sa_q;
  assign rd_reg_b = sb_q;
  assign rd_elem  = rcnt_q[EW-1:0];
  assign busy     = busy_q;
  assign done     = done_q;
  assign cur_dst  = dst_q;
  assign cur_sa   = sa_q;
  assign cur_sb   = sb_q;
  assign cur_len  = len_q;
  assign wcnt     = wcnt_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_all_written_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (wcnt_q == len_q) && !busy_q);
  assert_write_behind_read_R4: assert property (@(posedge clk) disable iff (rst)
    wcnt_q <= rcnt_q);
  assert_read_in_length_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (rcnt_q <= len_q));
endmodule

// File: rtl/vchain_top.sv
module vchain_top
  import vchain_pkg::*;
#(
  parameter int REG_N   = vchain_pkg::REG_N,
  parameter int ELEM_N  = vchain_pkg::ELEM_N,
  parameter int DW      = vchain_pkg::DW,
  parameter int ADD_LAT = vchain_pkg::ADD_LAT,
  parameter int MUL_LAT = vchain_pkg::MUL_LAT,
  localparam int RW = $clog2(REG_N),
  localparam int EW = $clog2(ELEM_N),
  localparam int LW = $clog2(ELEM_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  output logic          iss_ready,
  input  logic          iss_op,
  input  logic [RW-1:0] iss_dst,
  input  logic [RW-1:0] iss_src_a,
  input  logic [RW-1:0] iss_src_b,
  input  logic [LW-1:0] iss_len,
  output logic          busy,
  output logic [NU-1:0] done,
  input  logic          hst_we,
  input  logic [RW-1:0] hst_reg,
  input  logic [EW-1:0] hst_elem,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata
);
  localparam int RP = 2 * NU;

  logic [RW-1:0] rreg   [RP];
  logic [EW-1:0] relem  [RP];
  logic [DW-1:0] rdat   [RP];
  logic          wen    [NU];
  logic [RW-1:0] wreg   [NU];
  logic [EW-1:0] welem  [NU];
  logic [DW-1:0] wdat   [NU];
  logic [EW-1:0] uelem  [NU];
  logic          busy_v [NU];
  logic          done_v [NU];
  logic          start_v[NU];
  logic [RW-1:0] dst_v  [NU];
  logic [RW-1:0] sa_v   [NU];
  logic [RW-1:0] sb_v   [NU];
  logic [LW-1:0] len_v  [NU];
  logic [LW-1:0] wcnt_v [NU];

  logic u, o, raw, war, waw, fire;

  always_comb begin
    u   = iss_op;
    o   = ~iss_op;
    raw = busy_v[o] && ((iss_src_a == dst_v[o]) || (iss_src_b == dst_v[o]));
    war = busy_v[o] && ((iss_dst == sa_v[o]) || (iss_dst == sb_v[o]));
    waw = busy_v[o] && (iss_dst == dst_v[o]);
    iss_ready = !busy_v[u] && !war && !waw && (!raw || (iss_len <= len_v[o]));
  end

  assign fire = iss_valid && iss_ready;
  assign busy = busy_v[0] | busy_v[1];

  for (genvar g = 0; g < NU; g++) begin : g_unit
    assign start_v[g] = fire && (iss_op == 1'(g));

    vchain_unit #(
      .DW(DW), .RW(RW), .EW(EW), .LW(LW),
      .LAT((g == 1) ? MUL_LAT : ADD_LAT),
      .IS_MUL(g == 1)
    ) u_unit (
      .clk(clk), .rst(rst),
      .start(start_v[g]),
      .s_dst(iss_dst), .s_sa(iss_src_a), .s_sb(iss_src_b),
      .s_len(iss_len), .s_chain(raw),
      .other_busy(busy_v[1-g]), .other_wcnt(wcnt_v[1-g]),
      .rd_reg_a(rreg[2*g]), .rd_reg_b(rreg[2*g+1]), .rd_elem(uelem[g]),
      .rd_data_a(rdat[2*g]), .rd_data_b(rdat[2*g+1]),
      .wr_en(wen[g]), .wr_reg(wreg[g]), .wr_elem(welem[g]), .wr_data(wdat[g]),
      .busy(busy_v[g]), .done(done_v[g]),
      .cur_dst(dst_v[g]), .cur_sa(sa_v[g]), .cur_sb(sb_v[g]),
      .cur_len(len_v[g]), .wcnt(wcnt_v[g])
    );

    assign relem[2*g]   = uelem[g];
    assign relem[2*g+1] = uelem[g];
    assign done[g]      = done_v[g];
  end

  vchain_regbank #(
    .REG_N(REG_N), .ELEM_N(ELEM_N), .DW(DW), .RP(RP), .WP(NU), .RW(RW), .EW(EW)
  ) u_bank (
    .clk(clk),
    .wr_en(wen), .wr_reg(wreg), .wr_elem(welem), .wr_data(wdat),
    .rd_reg(rreg), .rd_elem(relem), .rd_data(rdat),
    .hst_we(hst_we), .hst_reg(hst_reg), .hst_elem(hst_elem),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy);
  assert_no_write_clash_R7: assert property (@(posedge clk) disable iff (rst)
    (wen[0] && wen[1]) |-> (wreg[0] != wreg[1]));
  assert_accept_starts_R8: assert property (@(posedge clk) disable iff (rst)
    fire |=> busy);
endmodule

// File: tb/sim_vchain_top.sv
module sim_vchain_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic        iss_op = 1'b0;
  logic [2:0]  iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic [6:0]  iss_len = '0;
  logic        busy;
  logic [1:0]  done;
  logic        hst_we = 1'b0;
  logic [2:0]  hst_reg = '0;
  logic [5:0]  hst_elem = '0;
  logic [63:0] hst_wdata = '0;
  logic [63:0] hst_rdata;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] mdl [8][64];

  // program: {op, dst, src_a, src_b, len}
  localparam logic [16:0] PROG [8] = '{
    {1'b1, 3'd2, 3'd0, 3'd1, 7'd64},
    {1'b0, 3'd3, 3'd2, 3'd0, 7'd64},
    {1'b0, 3'd4, 3'd5, 3'd6, 7'd1},
    {1'b1, 3'd5, 3'd4, 3'd4, 7'd33},
    {1'b1, 3'd6, 3'd7, 3'd7, 7'd17},
    {1'b0, 3'd7, 3'd6, 3'd1, 7'd17},
    {1'b0, 3'd0, 3'd0, 3'd0, 7'd64},
    {1'b1, 3'd1, 3'd0, 3'd3, 7'd5}
  };

  vchain_top u0 (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_len(iss_len), .busy(busy), .done(done),
    .hst_we(hst_we), .hst_reg(hst_reg), .hst_elem(hst_elem),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] seed(input int r, input int e);
    return (64'(r * 64 + e + 1) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(e) << (r * 7));
  endfunction

  task automatic host_write(input int r, input int e, input logic [63:0] d);
    hst_we = 1'b1; hst_reg = 3'(r); hst_elem = 6'(e); hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic host_read(input int r, input int e, output logic [63:0] d);
    hst_reg = 3'(r); hst_elem = 6'(e);
    @(negedge clk);
    d = hst_rdata;
  endtask

  task automatic check_reg(input int r, input string req);
    logic [63:0] d, bad_a, bad_e;
    int bad_i;
    bad_i = -1; bad_a = '0; bad_e = '0;
    for (int e = 0; e < 64; e++) begin
      host_read(r, e, d);
      if (d !== mdl[r][e] && bad_i < 0) begin
        bad_i = e; bad_a = d; bad_e = mdl[r][e];
      end
    end
    check(bad_i < 0, req, $sformatf("V%0d element %0d", r, bad_i), bad_a, bad_e);
  endtask

  task automatic model_apply(input logic op, input int d, input int a, input int b,
                             input int len);
    for (int i = 0; i < len; i++)
      mdl[d][i] = op ? mdl[a][i] * mdl[b][i] : mdl[a][i] + mdl[b][i];
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input logic op, input int d, input int a, input int b,
                       input int len, output int fcyc);
    iss_op = op; iss_dst = 3'(d); iss_src_a = 3'(a); iss_src_b = 3'(b);
    iss_len = 7'(len); iss_valid = 1'b1;
    #1;
    while (!iss_ready) begin
      @(negedge clk); #1;
    end
    fcyc = cyc;
    @(negedge clk);
    iss_valid = 1'b0;
    model_apply(op, d, a, b, len);
  endtask

  task automatic wait_done(input int un, output int dcyc);
    while (!done[un]) @(negedge clk);
    dcyc = cyc;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic probe(input logic op, input int d, input int a, input int b,
                       input int len);
    iss_op = op; iss_dst = 3'(d); iss_src_a = 3'(a); iss_src_b = 3'(b);
    iss_len = 7'(len);
    #1;
  endtask

  initial begin
    while (cyc < WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
    finish_run();
  end

  initial begin
    int f, f2, dn;
    logic [63:0] d;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
    check(done == 2'b00, "R1", "done after reset", 64'(done), 64'd0);
    check(iss_ready == 1'b1, "R1", "ready after reset", 64'(iss_ready), 64'd1);

    for (int r = 0; r < 8; r++)
      for (int e = 0; e < 64; e++) begin
        mdl[r][e] = seed(r, e);
        host_write(r, e, mdl[r][e]);
      end

    // R10 host read path and its one-cycle latency
    host_read(3, 7, d);
    check(d == mdl[3][7], "R10", "host read V3[7]", d, mdl[3][7]);
    hst_reg = 3'd5; hst_elem = 6'd9;
    #1;
    check(hst_rdata == mdl[3][7], "R10", "read data held one cycle", hst_rdata, mdl[3][7]);
    @(negedge clk);
    check(hst_rdata == mdl[5][9], "R10", "host read V5[9]", hst_rdata, mdl[5][9]);

    // stimulus table: back-to-back mix of chained, stalled and in-place ops
    for (int p = 0; p < 8; p++)
      issue(PROG[p][16], int'(PROG[p][15:13]), int'(PROG[p][12:10]),
            int'(PROG[p][9:7]), int'(PROG[p][6:0]), f);
    wait_idle();
    for (int r = 0; r < 8; r++) check_reg(r, "R2 R3 R5 R7");

    // R4 lone add, length 64
    issue(1'b0, 4, 0, 1, 64, f);
    wait_done(0, dn);
    check(dn - f == 70, "R4", "add done delay", 64'(dn - f), 64'd70);
    check(busy == 1'b0, "R9", "busy in done cycle", 64'(busy), 64'd0);
    @(negedge clk);
    check(done[0] == 1'b0, "R9", "done pulse width", 64'(done[0]), 64'd0);

    // R4 lone multiply, length 10
    issue(1'b1, 5, 2, 3, 10, f);
    wait_done(1, dn);
    check(dn - f == 17, "R4", "mul done delay", 64'(dn - f), 64'd17);
    wait_idle();
    check_reg(5, "R3");

    // R5 chained multiply then add, length 64
    issue(1'b1, 6, 1, 2, 64, f);
    issue(1'b0, 7, 6, 3, 64, f2);
    check(f2 - f == 1, "R5", "dependent add accepted next cycle", 64'(f2 - f), 64'd1);
    wait_done(0, dn);
    check(dn - f == 77, "R5", "chained pair done delay", 64'(dn - f), 64'd77);
    wait_idle();
    check_reg(6, "R3");
    check_reg(7, "R5");

    // R6 dependent longer than producer: no chaining
    issue(1'b1, 1, 4, 5, 8, f);
    probe(1'b0, 2, 1, 0, 16);
    check(iss_ready == 1'b0, "R6", "longer dependent held", 64'(iss_ready), 64'd0);
    issue(1'b0, 2, 1, 0, 16, f2);
    wait_done(0, dn);
    check(dn - f == 37, "R6", "sequential pair done delay", 64'(dn - f), 64'd37);
    wait_idle();
    check_reg(2, "R6");

    // R7 / R8 issue hazards against a running multiply
    issue(1'b1, 2, 3, 4, 20, f);
    probe(1'b0, 3, 5, 6, 4);
    check(iss_ready == 1'b0, "R7", "write to running source held", 64'(iss_ready), 64'd0);
    probe(1'b0, 2, 5, 6, 4);
    check(iss_ready == 1'b0, "R7", "write to running destination held", 64'(iss_ready), 64'd0);
    probe(1'b1, 0, 5, 6, 4);
    check(iss_ready == 1'b0, "R8", "second multiply held", 64'(iss_ready), 64'd0);
    issue(1'b0, 3, 5, 6, 4, f2);
    wait_idle();
    check_reg(2, "R7");
    check_reg(3, "R7");

    // R2 length 1: only element 0 changes
    issue(1'b0, 0, 1, 2, 1, f);
    wait_done(0, dn);
    check(dn - f == 7, "R2 R4", "length-1 add done delay", 64'(dn - f), 64'd7);
    wait_idle();
    check_reg(0, "R2");

    finish_run();
  end
endmodule